// File: doc/BRIEF.md
# Data-Strobe Serial Line Codec

This block turns parallel words from a link layer into a serial data-strobe bit stream for one cable port, and turns an incoming data-strobe pair back into parallel words. The data line carries the bits as they are. The strobe line toggles only when a bit repeats the one before it. As a result, exactly one of the two lines changes in every bit period, and the exclusive-OR of the two lines toggles once per bit. A single-cycle bit enable, `bit_en`, stands in for the fast serial clock: one bit leaves the transmitter on each cycle in which it is high.

The word width follows a 3-bit speed code taken at the start of a packet: 2, 4 or 8 bits per word. The transmitter sends the encoded data on its B output and the encoded strobe on its A output. The receiver takes data from its A input and strobe from its B input. When the requested speed is one that the far port cannot run, the transmitter sends no bits. Instead it parks its outputs in a fixed prefix level until the packet is ended. While the port is receiving, the output enable of the transmitter stays off.

Transmit states are `TX_IDLE`, `TX_SEND` and `TX_HOLD`. The transitions are:
- `TX_IDLE`→`TX_SEND` on `tx_start` with a supported speed.
- `TX_IDLE`→`TX_HOLD` on `tx_start` with an unsupported speed.
- `TX_SEND`→`TX_IDLE` and `TX_HOLD`→`TX_IDLE` on `tx_end`.

Receive states are `RX_OFF` and `RX_ON`. The transitions are:
- `RX_OFF`→`RX_ON` when `rcv_mode` is high.
- `RX_ON`→`RX_OFF` when `rcv_mode` is low.

Top module: `ds_codec`

## Requirements
- R1: In reset, and in the first cycle after it, `tx_oe`, `tx_ready`, `tpa_out`, `tpb_out` and `rx_valid` are all 0.
- R2: Speed code 000 selects 2-bit words, 001 selects 4-bit words and 010 selects 8-bit words. The transmit code is taken on `tx_start` and the receive code on the rise of `rcv_mode`. Later changes to either code have no effect on the packet in progress.
- R3: Each word is taken from the low bits of `tx_word` and sent most significant bit first.
- R4: Between successive bits, exactly one output line changes. The strobe (A output) toggles when a bit equals the previous one; otherwise the data (B output) changes.
- R5: The encoded data leaves on `tpb_out` and the strobe on `tpa_out`. The receiver takes data from `tpa_in` and strobe from `tpb_in`.
- R6: A speed code above 010, or above `port_speed`, leads to `TX_HOLD`. In that state `tpb_out`=0, `tpa_out`=1, `tx_oe`=1 (when not receiving) and `tx_ready`=0.
- R7: `tx_oe` is 0 in every cycle in which `rcv_mode` is 1.
- R8: In `RX_ON`, each change of `tpa_in` XOR `tpb_in` samples `tpa_in`. After a full word of samples, `rx_word` holds them right-aligned, with the first sample as the most significant bit and the upper bits 0. `rx_valid` is high for one cycle.
- R9: In `TX_SEND`, the outputs change only on cycles in which `bit_en` is high.
- R10: `tx_end` returns the transmitter to `TX_IDLE`. The next cycle shows `tx_oe`=0 and both output lines at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit period per high cycle |
| tx_start | input | 1 | Begin a transmit packet, taking `tx_speed` |
| tx_speed | input | 3 | Requested speed code |
| port_speed | input | 3 | Highest speed code the far port accepts |
| tx_end | input | 1 | End the transmit packet |
| tx_valid | input | 1 | `tx_word` is offered |
| tx_word | input | 8 | Parallel transmit word, low bits used |
| tx_ready | output | 1 | Serializer empty, a word is taken when `tx_valid` is high |
| tx_oe | output | 1 | Line driver enable |
| tpa_out | output | 1 | Strobe line, A output |
| tpb_out | output | 1 | Data line, B output |
| rcv_mode | input | 1 | Port is receiving; enables the receiver and turns off the drivers |
| rx_speed | input | 3 | Receive speed code, taken when `rcv_mode` rises |
| tpa_in | input | 1 | Received data line |
| tpb_in | input | 1 | Received strobe line |
| rx_word | output | 8 | Recovered word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is new |

## Verification
The bench builds the block with its default parameters: an 8-bit maximum word and a 3-bit speed code. With these values all three widths (2, 4 and 8) can be reached, along with both hold cases: a code above the port's limit and the out-of-range code 011. The transmit lines are looped back into the receive inputs with the pair roles crossed. The serial stream is therefore decoded twice: once by the bench from the line changes, and once by the receiver. A run with `bit_en` toggling every other cycle shows that bit timing follows the enable alone.

// File: rtl/ds_codec_pkg.sv
package ds_codec_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_HOLD
    } tx_state_t;

    typedef enum logic {
        RX_OFF,
        RX_ON
    } rx_state_t;

    // bits per parallel word for a legal speed code
    function automatic int lanes_of(input logic [2:0] code);
        return 2 << code;
    endfunction

endpackage

// File: rtl/ds_tx_ser.sv
module ds_tx_ser
    import ds_codec_pkg::*;
#(
    parameter int MAX_W = 8,
    parameter int SPD_W = 3,
    parameter int CNT_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             start,
    input  logic [SPD_W-1:0] spd,
    input  logic [SPD_W-1:0] port_spd,
    input  logic             end_pkt,
    input  logic             valid,
    input  logic [MAX_W-1:0] word,
    input  logic             rcv_mode,
    output logic             ready,
    output logic             oe,
    output logic             d_line,
    output logic             s_line,
    output tx_state_t        state_o
);

    localparam int MAX_CODE = $clog2(MAX_W) - 1;

    tx_state_t        st, st_nx;
    logic [MAX_W-1:0] sh;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wid;
    logic [CNT_W-1:0] sh_amt;
    logic             supported;
    logic             d_q, s_q;

    assign supported = (spd <= SPD_W'(MAX_CODE)) && (spd <= port_spd);
    assign sh_amt    = CNT_W'(MAX_W) - wid;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE: if (start)   st_nx = supported ? TX_SEND : TX_HOLD;
            TX_SEND: if (end_pkt) st_nx = TX_IDLE;
            TX_HOLD: if (end_pkt) st_nx = TX_IDLE;
            default:              st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
            wid <= '0;
            d_q <= 1'b0;
            s_q <= 1'b0;
        end else begin
            unique case (st)
                TX_IDLE: begin
                    d_q <= 1'b0;
                    s_q <= 1'b0;
                    cnt <= '0;
                    if (start) begin
                        wid <= CNT_W'(lanes_of(spd));
                        if (!supported) s_q <= 1'b1;
                    end
                end
                TX_SEND: begin
                    if (end_pkt) begin
                        d_q <= 1'b0;
                        s_q <= 1'b0;
                        cnt <= '0;
                    end else if (cnt == '0) begin
                        if (valid) begin
                            sh  <= word << sh_amt;
                            cnt <= wid;
                        end
                    end else if (bit_en) begin
                        d_q <= sh[MAX_W-1];
                        s_q <= (sh[MAX_W-1] == d_q) ? ~s_q : s_q;
                        sh  <= sh << 1;
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                TX_HOLD: begin
                    if (end_pkt) begin
                        d_q <= 1'b0;
                        s_q <= 1'b0;
                    end
                end
                default: begin
                    d_q <= 1'b0;
                    s_q <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        ready   = (st == TX_SEND) && (cnt == '0);
        oe      = (st != TX_IDLE) && !rcv_mode;
        d_line  = d_q;
        s_line  = s_q;
        state_o = st;
    end

endmodule

// File: rtl/ds_rx_deser.sv
module ds_rx_deser
    import ds_codec_pkg::*;
#(
    parameter int MAX_W = 8,
    parameter int SPD_W = 3,
    parameter int CNT_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rcv_mode,
    input  logic [SPD_W-1:0] spd,
    input  logic             line_d,
    input  logic             line_s,
    output logic [MAX_W-1:0] word,
    output logic             valid
);

    localparam int MAX_CODE = $clog2(MAX_W) - 1;

    rx_state_t        st, st_nx;
    logic [MAX_W-2:0] sh;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wid;
    logic             par_q;
    logic             evt;
    logic [MAX_W-1:0] word_nx;
    logic [MAX_W-1:0] word_q;
    logic             valid_q;

    assign evt     = (line_d ^ line_s) != par_q;
    assign word_nx = {sh, line_d} & ~({MAX_W{1'b1}} << wid);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_OFF;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_OFF:  if (rcv_mode)  st_nx = RX_ON;
            RX_ON:   if (!rcv_mode) st_nx = RX_OFF;
            default:                st_nx = RX_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            cnt     <= '0;
            wid     <= CNT_W'(MAX_W);
            par_q   <= 1'b0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            par_q   <= line_d ^ line_s;
            valid_q <= 1'b0;
            unique case (st)
                RX_OFF: begin
                    cnt <= '0;
                    sh  <= '0;
                    wid <= (spd > SPD_W'(MAX_CODE)) ? CNT_W'(MAX_W)
                                                    : CNT_W'(lanes_of(spd));
                end
                RX_ON: begin
                    if (evt) begin
                        sh <= word_nx[MAX_W-2:0] | {sh[MAX_W-3:0], line_d};
                        if (cnt == wid - CNT_W'(1)) begin
                            word_q  <= word_nx;
                            valid_q <= 1'b1;
                            cnt     <= '0;
                            sh      <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    always_comb begin
        word  = word_q;
        valid = valid_q;
    end

endmodule

// File: rtl/ds_codec.sv
module ds_codec
    import ds_codec_pkg::*;
#(
    parameter int MAX_W = 8,
    parameter int SPD_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             tx_start,
    input  logic [SPD_W-1:0] tx_speed,
    input  logic [SPD_W-1:0] port_speed,
    input  logic             tx_end,
    input  logic             tx_valid,
    input  logic [MAX_W-1:0] tx_word,
    output logic             tx_ready,
    output logic             tx_oe,
    output logic             tpa_out,
    output logic             tpb_out,
    input  logic             rcv_mode,
    input  logic [SPD_W-1:0] rx_speed,
    input  logic             tpa_in,
    input  logic             tpb_in,
    output logic [MAX_W-1:0] rx_word,
    output logic             rx_valid
);

    localparam int CNT_W = $clog2(MAX_W + 1);

    tx_state_t tx_state;
    logic      enc_d, enc_s;

    ds_tx_ser #(.MAX_W(MAX_W), .SPD_W(SPD_W), .CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .start    (tx_start),
        .spd      (tx_speed),
        .port_spd (port_speed),
        .end_pkt  (tx_end),
        .valid    (tx_valid),
        .word     (tx_word),
        .rcv_mode (rcv_mode),
        .ready    (tx_ready),
        .oe       (tx_oe),
        .d_line   (enc_d),
        .s_line   (enc_s),
        .state_o  (tx_state)
    );

    // pair roles: data on B, strobe on A when sending
    assign tpb_out = enc_d;
    assign tpa_out = enc_s;

    // pair roles swap when receiving: data on A, strobe on B
    ds_rx_deser #(.MAX_W(MAX_W), .SPD_W(SPD_W), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rcv_mode (rcv_mode),
        .spd      (rx_speed),
        .line_d   (tpa_in),
        .line_s   (tpb_in),
        .word     (rx_word),
        .valid    (rx_valid)
    );

endmodule

// File: rtl/ds_codec_chk.sv
module ds_codec_chk
    import ds_codec_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      bit_en,
    input logic      tx_end,
    input logic      tx_ready,
    input logic      tx_oe,
    input logic      tpa_out,
    input logic      tpb_out,
    input logic      rcv_mode,
    input logic      rx_valid,
    input tx_state_t tx_st
);

    p_oe_off_rcv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_mode |-> !tx_oe);

    p_hold_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_st == TX_HOLD) |-> (!tpb_out && tpa_out && !tx_ready));

    p_one_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_st == TX_SEND && $past(tx_st) == TX_SEND) |->
        ($countones({tpa_out ^ $past(tpa_out), tpb_out ^ $past(tpb_out)}) <= 1));

    p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_st == TX_SEND && !bit_en && !tx_end) |=>
        ($stable(tpa_out) && $stable(tpb_out)));

    p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_end && tx_st != TX_IDLE) |=> (!tx_oe && !tpa_out && !tpb_out));

    p_rx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

bind ds_codec ds_codec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .tx_end   (tx_end),
    .tx_ready (tx_ready),
    .tx_oe    (tx_oe),
    .tpa_out  (tpa_out),
    .tpb_out  (tpb_out),
    .rcv_mode (rcv_mode),
    .rx_valid (rx_valid),
    .tx_st    (tx_state)
);

// File: tb/ds_codec_test.sv
module ds_codec_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b1;
    logic       tx_start = 1'b0;
    logic [2:0] tx_speed = 3'b000;
    logic [2:0] port_speed = 3'b010;
    logic       tx_end = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       tx_ready, tx_oe, tpa_out, tpb_out;
    logic       rcv_mode = 1'b0;
    logic [2:0] rx_speed = 3'b000;
    logic [7:0] rx_word;
    logic       rx_valid;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic slow = 1'b0;

    always #10 clk = ~clk;

    ds_codec uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .tx_start(tx_start), .tx_speed(tx_speed), .port_speed(port_speed),
        .tx_end(tx_end), .tx_valid(tx_valid), .tx_word(tx_word),
        .tx_ready(tx_ready), .tx_oe(tx_oe), .tpa_out(tpa_out), .tpb_out(tpb_out),
        .rcv_mode(rcv_mode), .rx_speed(rx_speed),
        .tpa_in(tpb_out), .tpb_in(tpa_out),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    // line monitor: decodes bits from line changes, collects received words
    logic       col_en = 1'b0;
    logic       col_q = 1'b0;
    logic       pa = 1'b0, pb = 1'b0;
    logic       bits [32];
    int         bcyc [32];
    int         nb = 0;
    logic [7:0] rxw [4];
    int         nr = 0;
    int         both = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        bit_en <= slow ? ~bit_en : 1'b1;
        if (col_en && !col_q) begin
            nb = 0; nr = 0; both = 0;
        end
        if (col_en) begin
            if ((tpa_out != pa) && (tpb_out != pb)) both = both + 1;
            else if ((tpa_out != pa) || (tpb_out != pb)) begin
                if (nb < 32) begin
                    bits[nb] = tpb_out;
                    bcyc[nb] = cyc;
                end
                nb = nb + 1;
            end
            if (rx_valid) begin
                if (nr < 4) rxw[nr] = rx_word;
                nr = nr + 1;
            end
        end
        col_q = col_en;
        pa = tpa_out;
        pb = tpb_out;
    end

    task automatic check(input logic ok, input string req, input int got, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wait_ready();
        int g = 0;
        while (!tx_ready && g < 200) begin
            @(negedge clk);
            g = g + 1;
        end
    endtask

    task automatic run_pkt(input logic [2:0] spd, input logic [2:0] port,
                           input logic [7:0] w0, input logic [7:0] w1);
        int wid = 2 << spd;
        logic ok = (spd <= 3'b010) && (spd <= port);
        logic [7:0] msk = ~(8'hFF << wid);
        @(negedge clk);
        if (ok) begin
            rcv_mode = 1'b1;
            rx_speed = spd;
            @(negedge clk);
            rx_speed = 3'b111;          // R2: late change ignored
            col_en = 1'b1;
            tx_speed = spd;
            port_speed = port;
            tx_start = 1'b1;
            @(negedge clk);
            tx_start = 1'b0;
            tx_speed = 3'b111;          // R2: late change ignored
            check(tx_oe == 1'b0, "R7", int'(tx_oe), 0);
            wait_ready();
            tx_valid = 1'b1; tx_word = w0;
            @(negedge clk);
            tx_valid = 1'b0;
            wait_ready();
            tx_valid = 1'b1; tx_word = w1;
            @(negedge clk);
            tx_valid = 1'b0;
            wait_ready();
            repeat (3) @(negedge clk);
            col_en = 1'b0;
            rcv_mode = 1'b0;
            tx_end = 1'b1;
            @(negedge clk);
            tx_end = 1'b0;
            check(!tx_oe && !tpa_out && !tpb_out, "R10", {tx_oe, tpa_out, tpb_out}, 0);
            check(nb == 2 * wid, "R2", nb, 2 * wid);
            check(both == 0, "R4", both, 0);
            for (int i = 0; i < 2 * wid && i < nb && i < 32; i++) begin
                logic e = (i < wid) ? w0[wid - 1 - i] : w1[2 * wid - 1 - i];
                check(bits[i] == e, "R3 R5", int'(bits[i]), int'(e));
                if (slow && i > 0)
                    check(bcyc[i] - bcyc[i-1] >= 2, "R9", bcyc[i] - bcyc[i-1], 2);
            end
            check(nr == 2, "R8", nr, 2);
            if (nr >= 2) begin
                check(rxw[0] == (w0 & msk), "R8 R5", rxw[0], w0 & msk);
                check(rxw[1] == (w1 & msk), "R8 R5", rxw[1], w1 & msk);
            end
        end else begin
            rcv_mode = 1'b0;
            tx_speed = spd;
            port_speed = port;
            tx_start = 1'b1;
            @(negedge clk);
            tx_start = 1'b0;
            tx_valid = 1'b1; tx_word = w0;
            repeat (4) begin
                check(!tpb_out && tpa_out && tx_oe && !tx_ready, "R6",
                      {tpb_out, tpa_out, tx_oe, tx_ready}, 4'b0110);
                @(negedge clk);
            end
            tx_valid = 1'b0;
            rcv_mode = 1'b1;
            @(negedge clk);
            check(tx_oe == 1'b0, "R7", int'(tx_oe), 0);
            rcv_mode = 1'b0;
            tx_end = 1'b1;
            @(negedge clk);
            tx_end = 1'b0;
            check(!tx_oe && !tpa_out && !tpb_out, "R10", {tx_oe, tpa_out, tpb_out}, 0);
        end
    endtask

    // {tx speed, port speed, word0, word1}
    localparam logic [21:0] VEC [7] = '{
        {3'b000, 3'b010, 8'h02, 8'h03},
        {3'b001, 3'b010, 8'h5C, 8'h09},
        {3'b010, 3'b010, 8'hB4, 8'h00},
        {3'b010, 3'b010, 8'hFF, 8'h01},
        {3'b010, 3'b001, 8'h3C, 8'hC3},
        {3'b011, 3'b010, 8'h11, 8'h22},
        {3'b001, 3'b001, 8'h06, 8'hFA}
    };

    initial begin
        repeat (3) @(negedge clk);
        check(!tx_oe && !tx_ready && !tpa_out && !tpb_out && !rx_valid, "R1",
              {tx_oe, tx_ready, tpa_out, tpb_out, rx_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_oe && !tx_ready && !tpa_out && !tpb_out && !rx_valid, "R1",
              {tx_oe, tx_ready, tpa_out, tpb_out, rx_valid}, 0);

        for (int v = 0; v < 7; v++)
            run_pkt(VEC[v][21:19], VEC[v][18:16], VEC[v][15:8], VEC[v][7:0]);

        // R9: bit enable every other cycle
        slow = 1'b1;
        run_pkt(3'b010, 3'b010, 8'h96, 8'h69);
        run_pkt(3'b000, 3'b000, 8'h01, 8'h00);
        slow = 1'b0;

        // R4: long run of equal bits moves only the strobe
        run_pkt(3'b010, 3'b010, 8'h00, 8'hFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        bad = bad + 1;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule